// File: doc/BRIEF.md
# Write-Through Level-One Data Cache

This block is a set-associative first-level data cache placed between a load/store unit and the port of the next memory level. Capacity, number of ways and line length are parameters. The defaults are 16 KB, 4 ways and 32-byte lines. Data moves to and from the core one 32-bit word at a time, with per-byte enables on stores. Towards the next level the block issues single-word writes, single-word reads and full-line reads. A full line comes back in one response beat.

Every store goes out to the next level. A store that finds its line resident also merges its bytes into the cached copy. A store that misses leaves the cache untouched. Integer loads that hit return their word on a fixed two-cycle schedule, and back-to-back hits are accepted every cycle. An integer load that misses fetches its whole line, installs it in a way chosen by a tree pseudo-LRU, and then returns the word.

Loads marked as floating point never consult the tag store. They read one word straight from the next level and do not install anything. Cached lines are never dirty, so evicting one needs no write-back. Only one transaction to the next level is outstanding at a time, and the core port stalls until it finishes.

Top module: `l1d_wt_cache`

## Requirements
- R1: After reset every line is invalid. The core port is ready, and neither a core response nor a next-level request is pending.
- R2: An integer load that hits, presented in cycle N, raises `core_rsp_valid` with the addressed word in cycle N+2 and causes no next-level request.
- R3: An integer load that misses issues exactly one line read (`mem_req_line`=1, `mem_req_we`=0, address with the line-offset bits cleared). Word k of the line is `mem_rsp_data[32k+31:32k]`. The requested word is returned in the cycle after `mem_rsp_valid`, and later integer loads to any word of that line hit.
- R4: Every store, whatever its floating-point tag, issues exactly one write (`mem_req_we`=1, `mem_req_line`=0) that carries the core address, data and byte enables unchanged. A store produces no core response.
- R5: A store that hits merges the data bytes whose enable bit is set (bit b covers bits 8b+7:8b) into the cached word. A later integer load hit returns the merged word.
- R6: A store that misses installs no line, so a later integer load to the same address still issues a line read.
- R7: A floating-point load issues a single-word read (`mem_req_line`=0, `mem_req_we`=0) even when the line is resident, and returns `mem_rsp_data[31:0]` in the cycle after `mem_rsp_valid`. It installs no line.
- R8: Refills pick the victim with a tree pseudo-LRU that is updated by load hits, store hits and fills. With two ways the victim is the least recently used way. Evictions produce no write request.
- R9: While a next-level request is pending, `core_req_ready` is low. A request not yet accepted keeps its address and kind stable.
- R10: Integer load hits are accepted in consecutive cycles, and each one answers two cycles after its own acceptance, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Core request accepted this cycle when valid |
| core_req_addr | input | ADDR_W | Byte address |
| core_req_we | input | 1 | 1 = store, 0 = load |
| core_req_wdata | input | 32 | Store data |
| core_req_be | input | 4 | Store byte enables |
| core_req_fp | input | 1 | Floating-point tag (loads bypass the cache) |
| core_rsp_valid | output | 1 | Load data valid |
| core_rsp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_we | output | 1 | 1 = word write |
| mem_req_line | output | 1 | 1 = full-line read, 0 = single word |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Read response present (one cycle) |
| mem_rsp_data | input | LINE_BYTES*8 | Line data, or the word in bits 31:0 |

## Verification
The bench builds the cache with 256 bytes, two ways and 16-byte lines. That gives eight sets, so addresses 128 bytes apart collide in one set after only a few loads. With two ways the pseudo-LRU is exact LRU, so every eviction can be predicted by hand. Four words per line lets a burst of pipelined hits and a partial-byte store merge stay inside a single refilled line. The bench also changes its memory model behind a resident line, which separates the bypass path from the cached path by the data each one returns.

// File: rtl/l1d_pkg.sv
package l1d_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WT,
    ST_LREQ,
    ST_LWAIT,
    ST_FREQ,
    ST_FWAIT
  } l1d_state_e;

  // Merge new bytes into an old word under a byte-enable mask.
  function automatic logic [WORD_W-1:0] be_merge(
    input logic [WORD_W-1:0]     old_w,
    input logic [WORD_W-1:0]     new_w,
    input logic [WORD_BYTES-1:0] be
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < WORD_BYTES; b++)
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/l1d_tag_array.sv
module l1d_tag_array #(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAY_W-1:0] hit_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_vec[i]) hit_way = WAY_W'(i);
  end

endmodule

// File: rtl/l1d_data_array.sv
module l1d_data_array
  import l1d_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int SETS      = 128,
  parameter int LINE_BITS = 256,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int WPL    = LINE_BITS / WORD_W,
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [WAY_W-1:0]      rd_way,
  input  logic [WSEL_W-1:0]     rd_wsel,
  output logic [WORD_W-1:0]     rd_word,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [WAY_W-1:0]      fill_way,
  input  logic [LINE_BITS-1:0]  fill_line,
  input  logic                  st_en,
  input  logic [IDX_W-1:0]      st_idx,
  input  logic [WAY_W-1:0]      st_way,
  input  logic [WSEL_W-1:0]     st_wsel,
  input  logic [WORD_W-1:0]     st_data,
  input  logic [WORD_BYTES-1:0] st_be
);

  logic [LINE_BITS-1:0] line_q [SETS][WAYS];
  logic [WORD_W-1:0]    st_old;

  assign rd_word = line_q[rd_idx][rd_way][rd_wsel*WORD_W +: WORD_W];
  assign st_old  = line_q[st_idx][st_way][st_wsel*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (fill_en)
      line_q[fill_idx][fill_way] <= fill_line;
    else if (st_en)
      line_q[st_idx][st_way][st_wsel*WORD_W +: WORD_W] <= be_merge(st_old, st_data, st_be);
  end

endmodule

// File: rtl/l1d_plru.sv
module l1d_plru #(
  parameter int WAYS = 4,
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LVL   = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] vic_idx,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way
);

  // Heap-ordered tree: node n has children 2n and 2n+1; bit 0 unused.
  // A node bit of 1 points the victim search to its right child.
  function automatic logic [WAY_W-1:0] tree_pick(input logic [WAYS-1:0] b);
    int node;
    node = 1;
    for (int l = 0; l < LVL; l++) node = node * 2 + int'(b[node]);
    return WAY_W'(node - WAYS);
  endfunction

  function automatic logic [WAYS-1:0] tree_touch(input logic [WAYS-1:0] b,
                                                 input logic [WAY_W-1:0] way);
    logic [WAYS-1:0] r;
    int node;
    r    = b;
    node = int'(way) + WAYS;
    for (int l = 0; l < LVL; l++) begin
      r[node / 2] = (node % 2 == 0);
      node = node / 2;
    end
    return r;
  endfunction

  logic [WAYS-1:0] st_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else if (touch_en) begin
      st_q[touch_idx] <= tree_touch(st_q[touch_idx], touch_way);
    end
  end

  assign victim = tree_pick(st_q[vic_idx]);

endmodule

// File: rtl/l1d_wt_cache.sv
module l1d_wt_cache
  import l1d_pkg::*;
#(
  parameter int CACHE_BYTES = 16384,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 32,
  parameter int ADDR_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    core_req_valid,
  output logic                    core_req_ready,
  input  logic [ADDR_W-1:0]       core_req_addr,
  input  logic                    core_req_we,
  input  logic [31:0]             core_req_wdata,
  input  logic [3:0]              core_req_be,
  input  logic                    core_req_fp,
  output logic                    core_rsp_valid,
  output logic [31:0]             core_rsp_data,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic                    mem_req_we,
  output logic                    mem_req_line,
  output logic [31:0]             mem_req_wdata,
  output logic [3:0]              mem_req_be,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_data
);

  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int SETS      = CACHE_BYTES / (WAYS * LINE_BYTES);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int WPL       = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W    = $clog2(WPL);
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Address split helpers.
  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[2 +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // Stage 1: captured request.
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_we;
  logic [31:0]       s1_wdata;
  logic [3:0]        s1_be;
  logic              s1_fp;

  l1d_state_e state_q, state_d;
  logic [WAY_W-1:0] vic_q;

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] plru_victim;
  logic [31:0]      arr_word;
  logic             hit;

  // Named internal events.
  logic ev_accept, ev_load_hit, ev_store_hit, ev_miss, ev_fill, ev_fp_done, ev_need_fsm;
  logic touch_en;
  logic [WAY_W-1:0] touch_way;

  logic        rsp_v_q;
  logic [31:0] rsp_d_q;

  assign hit          = |hit_vec;
  assign ev_load_hit  = s1_valid && !s1_we && !s1_fp && hit;
  assign ev_store_hit = s1_valid && s1_we && hit;
  assign ev_miss      = s1_valid && !s1_we && !s1_fp && !hit;
  assign ev_need_fsm  = s1_valid && !ev_load_hit;
  assign ev_fill      = (state_q == ST_LWAIT) && mem_rsp_valid;
  assign ev_fp_done   = (state_q == ST_FWAIT) && mem_rsp_valid;

  assign core_req_ready = (state_q == ST_IDLE) && !ev_need_fsm;
  assign ev_accept      = core_req_valid && core_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_we    <= 1'b0;
      s1_wdata <= '0;
      s1_be    <= '0;
      s1_fp    <= 1'b0;
    end else begin
      s1_valid <= ev_accept;
      if (ev_accept) begin
        s1_addr  <= core_req_addr;
        s1_we    <= core_req_we;
        s1_wdata <= core_req_wdata;
        s1_be    <= core_req_be;
        s1_fp    <= core_req_fp;
      end
    end
  end

  l1d_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (f_index(s1_addr)),
    .rd_tag  (f_tag(s1_addr)),
    .hit_vec (hit_vec),
    .hit_way (hit_way),
    .wr_en   (ev_fill),
    .wr_idx  (f_index(s1_addr)),
    .wr_way  (vic_q),
    .wr_tag  (f_tag(s1_addr))
  );

  l1d_data_array #(.WAYS(WAYS), .SETS(SETS), .LINE_BITS(LINE_BITS)) u_data (
    .clk       (clk),
    .rd_idx    (f_index(s1_addr)),
    .rd_way    (hit_way),
    .rd_wsel   (f_wsel(s1_addr)),
    .rd_word   (arr_word),
    .fill_en   (ev_fill),
    .fill_idx  (f_index(s1_addr)),
    .fill_way  (vic_q),
    .fill_line (mem_rsp_data),
    .st_en     (ev_store_hit),
    .st_idx    (f_index(s1_addr)),
    .st_way    (hit_way),
    .st_wsel   (f_wsel(s1_addr)),
    .st_data   (s1_wdata),
    .st_be     (s1_be)
  );

  assign touch_en  = ev_load_hit || ev_store_hit || ev_fill;
  assign touch_way = ev_fill ? vic_q : hit_way;

  l1d_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .vic_idx   (f_index(s1_addr)),
    .victim    (plru_victim),
    .touch_en  (touch_en),
    .touch_idx (f_index(s1_addr)),
    .touch_way (touch_way)
  );

  // Next-level controller.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (s1_valid) begin
          if (s1_we)      state_d = ST_WT;
          else if (s1_fp) state_d = ST_FREQ;
          else if (!hit)  state_d = ST_LREQ;
        end
      end
      ST_WT:    if (mem_req_ready) state_d = ST_IDLE;
      ST_LREQ:  if (mem_req_ready) state_d = ST_LWAIT;
      ST_LWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      ST_FREQ:  if (mem_req_ready) state_d = ST_FWAIT;
      ST_FWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vic_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ev_miss) vic_q <= plru_victim;
    end
  end

  assign mem_req_valid = (state_q == ST_WT) || (state_q == ST_LREQ) || (state_q == ST_FREQ);
  assign mem_req_we    = (state_q == ST_WT);
  assign mem_req_line  = (state_q == ST_LREQ);
  assign mem_req_addr  = (state_q == ST_LREQ) ? f_line_base(s1_addr) : s1_addr;
  assign mem_req_wdata = s1_wdata;
  assign mem_req_be    = s1_be;

  // Response stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= ev_load_hit || ev_fill || ev_fp_done;
      if (ev_load_hit)     rsp_d_q <= arr_word;
      else if (ev_fill)    rsp_d_q <= mem_rsp_data[f_wsel(s1_addr)*WORD_W +: WORD_W];
      else if (ev_fp_done) rsp_d_q <= mem_rsp_data[WORD_W-1:0];
    end
  end

  assign core_rsp_valid = rsp_v_q;
  assign core_rsp_data  = rsp_d_q;

endmodule

// File: rtl/l1d_wt_cache_chk.sv
module l1d_wt_cache_chk #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic              core_req_we,
  input logic              core_req_fp,
  input logic              core_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_we,
  input logic              mem_req_line,
  input logic [WAYS-1:0]   hit_vec,
  input logic              ev_load_hit,
  input logic              ev_fill
);

  // R2
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_hit |=> core_rsp_valid);

  // R3
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> core_rsp_valid);

  // R4
  store_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_ready && core_req_we)
      |-> ##2 (mem_req_valid && mem_req_we && !mem_req_line));

  // R6
  line_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_line) |-> !mem_req_we);

  // R7
  fp_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_ready && core_req_fp && !core_req_we)
      |-> ##2 (mem_req_valid && !mem_req_line && !mem_req_we));

  // R8
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !core_req_ready);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_line)));

endmodule

bind l1d_wt_cache l1d_wt_cache_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_ready (core_req_ready),
  .core_req_we    (core_req_we),
  .core_req_fp    (core_req_fp),
  .core_rsp_valid (core_rsp_valid),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_req_we     (mem_req_we),
  .mem_req_line   (mem_req_line),
  .hit_vec        (hit_vec),
  .ev_load_hit    (ev_load_hit),
  .ev_fill        (ev_fill)
);

// File: tb/tb_l1d_wt_cache.sv
`timescale 1ns/1ps
module tb_l1d_wt_cache;

  localparam int LB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          core_req_valid = 1'b0;
  logic          core_req_ready;
  logic [31:0]   core_req_addr = '0;
  logic          core_req_we = 1'b0;
  logic [31:0]   core_req_wdata = '0;
  logic [3:0]    core_req_be = '0;
  logic          core_req_fp = 1'b0;
  logic          core_rsp_valid;
  logic [31:0]   core_rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [31:0]   mem_req_addr;
  logic          mem_req_we;
  logic          mem_req_line;
  logic [31:0]   mem_req_wdata;
  logic [3:0]    mem_req_be;
  logic          mem_rsp_valid = 1'b0;
  logic [LB*8-1:0] mem_rsp_data = '0;

  l1d_wt_cache #(.CACHE_BYTES(256), .WAYS(2), .LINE_BYTES(LB), .ADDR_W(32)) dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // Response log, sampled on the edge that ends each cycle.
  int          n_rsp = 0;
  int          rsp_cyc [64];
  logic [31:0] rsp_dat [64];

  always @(posedge clk) begin
    if (core_rsp_valid && n_rsp < 64) begin
      rsp_cyc[n_rsp] = cyc;
      rsp_dat[n_rsp] = core_rsp_data;
      n_rsp++;
    end
    cyc++;
  end

  // Next-level memory model, driven on the falling edge.
  logic [31:0] mem [256];
  int          n_line = 0, n_word = 0, n_wr = 0;
  logic [31:0] line_addr, wr_addr, wr_data;
  logic [3:0]  wr_be;
  int          stall_cycles = 0;
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr;
  bit          pend_line;

  initial for (int i = 0; i < 256; i++) mem[i] = {8'hA5, 8'(i), 16'(i * 37 + 5)};

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = '0;
        if (pend_line)
          for (int k = 0; k < LB / 4; k++) mem_rsp_data[k*32 +: 32] = mem[8'(pend_addr[9:2] + 8'(k))];
        else
          mem_rsp_data[31:0] = mem[pend_addr[9:2]];
        pend = 0;
      end else pend_cnt--;
    end
    if (stall_cycles > 0) begin
      mem_req_ready = 1'b0;
      stall_cycles--;
    end else mem_req_ready = 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[mem_req_addr[9:2]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
        n_wr++;
        wr_addr = mem_req_addr;
        wr_data = mem_req_wdata;
        wr_be   = mem_req_be;
      end else begin
        pend      = 1;
        pend_cnt  = 2;
        pend_addr = mem_req_addr;
        pend_line = mem_req_line;
        if (mem_req_line) begin
          n_line++;
          line_addr = mem_req_addr;
        end else n_word++;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] a, input logic fp,
                         output logic [31:0] d, output int lat);
    int n0, acc;
    n0 = n_rsp;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_addr = a; core_req_we = 1'b0; core_req_fp = fp;
    while (!core_req_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    core_req_valid = 1'b0;
    for (int t = 0; t < 100 && n_rsp == n0; t++) tick();
    d   = rsp_dat[n0];
    lat = rsp_cyc[n0] - acc;
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be,
                          input logic fp, output int dur, output bit hold_ok);
    int w0;
    logic [31:0] first_addr;
    bit seen;
    w0 = n_wr; hold_ok = 1; seen = 0; dur = 0;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_addr = a; core_req_we = 1'b1;
    core_req_wdata = wd; core_req_be = be; core_req_fp = fp;
    while (!core_req_ready) @(negedge clk);
    @(negedge clk);
    core_req_valid = 1'b0; core_req_we = 1'b0; core_req_fp = 1'b0;
    for (int t = 0; t < 100 && n_wr == w0; t++) begin
      tick();
      dur++;
      if (mem_req_valid) begin
        if (core_req_ready) hold_ok = 0;
        if (!seen) begin first_addr = mem_req_addr; seen = 1; end
        else if (mem_req_addr !== first_addr) hold_ok = 0;
      end
    end
    tick();
  endtask

  // Scenario tasks.
  task automatic t_reset();
    tick();
    chk("R1 ready", 32'(core_req_ready), 32'd1);
    chk("R1 rsp idle", 32'(core_rsp_valid), 32'd0);
    chk("R1 mem idle", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] d; int lat, l0;
    l0 = n_line;
    do_load(32'h28, 1'b0, d, lat);
    chk("R1 R3 first load refills", 32'(n_line - l0), 32'd1);
    chk("R3 line address aligned", line_addr, 32'h20);
    chk("R3 miss data", d, mem[32'h28 >> 2]);
    do_load(32'h24, 1'b0, d, lat);
    chk("R2 hit latency", 32'(lat), 32'd2);
    chk("R2 hit data", d, mem[32'h24 >> 2]);
    chk("R2 R3 no refill on hit", 32'(n_line - l0), 32'd1);
  endtask

  task automatic t_store_hit();
    logic [31:0] d, old, exp; int lat, dur, r0, l0; bit ok;
    old = mem[32'h24 >> 2];
    exp = {old[31:24], 8'h5A, old[15:8], 8'h3C};
    r0 = n_rsp; l0 = n_line;
    do_store(32'h24, 32'h11_5A_22_3C, 4'b0101, 1'b0, dur, ok);
    chk("R4 write address", wr_addr, 32'h24);
    chk("R4 write data", wr_data, 32'h115A223C);
    chk("R4 write enables", 32'(wr_be), 32'h5);
    chk("R4 no core response", 32'(n_rsp - r0), 32'd0);
    do_load(32'h24, 1'b0, d, lat);
    chk("R5 merged hit data", d, exp);
    chk("R5 still a hit", 32'(lat), 32'd2);
    chk("R5 no refill", 32'(n_line - l0), 32'd0);
  endtask

  task automatic t_store_miss();
    logic [31:0] d; int lat, dur, w0, l0; bit ok;
    w0 = n_wr;
    do_store(32'h34, 32'hCAFE0001, 4'b1111, 1'b1, dur, ok);
    chk("R4 fp-tagged store writes through", 32'(n_wr - w0), 32'd1);
    l0 = n_line;
    do_load(32'h34, 1'b0, d, lat);
    chk("R6 no allocate on store miss", 32'(n_line - l0), 32'd1);
    chk("R6 refilled data", d, 32'hCAFE0001);
  endtask

  task automatic t_fp();
    logic [31:0] d, stale; int lat, l0, w0;
    stale = mem[32'h20 >> 2];
    mem[32'h20 >> 2] = 32'hFEEDF00D;
    l0 = n_line; w0 = n_word;
    do_load(32'h20, 1'b0, d, lat);
    chk("R2 cached copy still served", d, stale);
    do_load(32'h20, 1'b1, d, lat);
    chk("R7 fp load bypasses cache", d, 32'hFEEDF00D);
    chk("R7 word read issued", 32'(n_word - w0), 32'd1);
    chk("R7 no line read", 32'(n_line - l0), 32'd0);
    do_load(32'h44, 1'b1, d, lat);
    chk("R7 uncached fp data", d, mem[32'h44 >> 2]);
    l0 = n_line;
    do_load(32'h44, 1'b0, d, lat);
    chk("R7 fp load installs nothing", 32'(n_line - l0), 32'd1);
  endtask

  task automatic t_plru();
    logic [31:0] d; int lat, l0, w0;
    l0 = n_line; w0 = n_wr;
    do_load(32'h050, 1'b0, d, lat);
    do_load(32'h0D0, 1'b0, d, lat);
    do_load(32'h054, 1'b0, d, lat);
    chk("R8 two misses then hit", 32'(n_line - l0), 32'd2);
    do_load(32'h150, 1'b0, d, lat);
    chk("R8 third tag refills", 32'(n_line - l0), 32'd3);
    do_load(32'h058, 1'b0, d, lat);
    chk("R8 recently used line kept", 32'(n_line - l0), 32'd3);
    chk("R8 kept line data", d, mem[32'h058 >> 2]);
    do_load(32'h0D0, 1'b0, d, lat);
    chk("R8 LRU line evicted", 32'(n_line - l0), 32'd4);
    chk("R8 no write-back", 32'(n_wr - w0), 32'd0);
  endtask

  task automatic t_backpressure();
    int dur; bit ok;
    tick();
    stall_cycles = 6;
    do_store(32'h60, 32'h0BAD_BEEF, 4'b1111, 1'b0, dur, ok);
    chk("R9 stalled store held and core blocked", 32'(ok), 32'd1);
    chk("R9 store waited for next level", 32'(dur >= 6), 32'd1);
    chk("R9 store landed", mem[32'h60 >> 2], 32'h0BADBEEF);
  endtask

  task automatic t_pipeline();
    int n0, acc; bit rdy;
    rdy = 1;
    n0 = n_rsp;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_we = 1'b0; core_req_fp = 1'b0; core_req_addr = 32'h24;
    rdy &= core_req_ready; acc = cyc;
    @(negedge clk); core_req_addr = 32'h28; rdy &= core_req_ready;
    @(negedge clk); core_req_addr = 32'h2C; rdy &= core_req_ready;
    @(negedge clk); core_req_valid = 1'b0;
    repeat (6) tick();
    chk("R10 accepted every cycle", 32'(rdy), 32'd1);
    chk("R10 three responses", 32'(n_rsp - n0), 32'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R10 pipelined latency", 32'(rsp_cyc[n0 + i] - acc), 32'(i + 2));
      chk("R10 pipelined data", rsp_dat[n0 + i], mem[(32'h24 >> 2) + i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_miss_hit();
    t_store_hit();
    t_store_miss();
    t_fp();
    t_plru();
    t_backpressure();
    t_pipeline();
    repeat (4) tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule